// File: doc/BRIEF.md
# Debug Console Entry Sequencer

This controller sits beside the instruction pipeline of a 16-bit processor. It decides when ordinary instruction execution stops so that an external debug console can take over, and when execution resumes. There are two ways in. The first is an active-low request pin that must be held low for a while. The second is a breakpoint instruction, which runs the stored console command at once. Each way in is gated by its own copy of the console-present configuration.

While in console mode the sequencer runs a short polling loop. One cycle of the loop reads the console command register. The loop watches the request pin and releases one command each time the pin rises. It pulses an execute strobe to an external command engine and waits for that engine to finish. It then halts until the pin falls again.

Two commands act on the sequencer itself. Code 0x0 leaves console mode: the pipeline is refilled and the timers restart. A short window after that exit gives exact single-instruction stepping. Code 0xB suspends the console. Execution stays parked until either a new pin request or a pending interrupt arrives; the interrupt redirects execution to its service routine.

States: RUN (normal execution), PEND (request registered, waiting for the instruction to finish), STEP (normal execution inside the single-step window), BP_READ (command read after a breakpoint), LOOP (polling loop with phases sample, read and idle), EXEC (execute pulse), BUSY (waiting for the command engine), HALT (waiting for a pin fall), SUSPEND (console parked after code 0xB), EXIT_CONT (leave after continue), EXIT_IRQ (leave towards the interrupt routine).

Transitions:
- RUN→PEND on a qualified pin request, or RUN→LOOP if the instruction also completes in that cycle.
- PEND→LOOP on instruction complete.
- RUN, PEND or STEP→BP_READ on a qualified breakpoint.
- BP_READ→EXEC.
- LOOP→EXEC when the pin is high in the sample phase.
- EXEC→EXIT_CONT, SUSPEND or BUSY, chosen by the command code.
- BUSY→HALT on command done.
- HALT→LOOP on pin low.
- SUSPEND→EXIT_IRQ on interrupt, otherwise SUSPEND→LOOP on pin low.
- EXIT_CONT→STEP.
- STEP→RUN when the window closes.
- EXIT_IRQ→RUN.

Top module: `console_entry_seq`

## Requirements
- R1: After reset, every output (cmd_rd, cmd_exec, timers_halt, refill_req, isr_resume, console_active) is low.
- R2: In normal execution, a pin request counts only if req_n is low for 2 consecutive clock cycles while cfg_int_present is high. A one-cycle low pulse is not a request. After a request is registered, console_active and the first cmd_rd appear in the cycle after the instr_done pulse, and not before it.
- R3: While req_n stays low in console mode, cmd_rd pulses once in every 3 cycles, and cmd_exec stays low.
- R4: When the loop finds req_n high in its sample phase, cmd_exec pulses for exactly one cycle within 3 cycles. The command that runs is the cmd_code captured at the most recent cmd_rd; changes to cmd_code after that read have no effect.
- R5: bp_hit with cfg_sys_present high gives cmd_rd in the next cycle and cmd_exec in the cycle after, whatever the state of req_n.
- R6: The pin route is gated only by cfg_int_present, and the breakpoint route only by cfg_sys_present. A route whose bit is low is ignored: console_active stays low.
- R7: timers_halt is high in every cycle that console_active is high, and low in every other cycle.
- R8: For any code other than 0x0 and 0xB, after cmd_exec the sequencer stays in console mode until cmd_done. It then issues no cmd_rd or cmd_exec while req_n stays high. The first cmd_rd comes in the cycle after req_n goes low.
- R9: Code 0x0 (continue) leaves console mode. In the cycle after cmd_exec, refill_req pulses for one cycle, and console_active and timers_halt are already low in that cycle.
- R10: From the cycle after a continue exit until the second fetch_strobe, a single low cycle of req_n (with cfg_int_present high) registers a request. Console mode is then re-entered in the cycle after the first instr_done. Once that window has closed, R2 applies again.
- R11: Code 0xB parks the console: console_active stays high and no cmd_rd is issued. If irq_pending is high, refill_req and isr_resume pulse in the next cycle. Otherwise a low req_n gives cmd_rd in the next cycle. If both arrive in the same cycle, the interrupt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per internal machine cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 1 | Active-low console request pin |
| bp_hit | input | 1 | Breakpoint instruction decoded |
| instr_done | input | 1 | Current instruction has completed |
| cfg_int_present | input | 1 | Console-present bit, internally held copy |
| cfg_sys_present | input | 1 | Console-present bit, freshly read system word |
| irq_pending | input | 1 | An interrupt is pending |
| cmd_code | input | 4 | Command code field of the console command register |
| cmd_done | input | 1 | Command engine finished the current command |
| fetch_strobe | input | 1 | Pipeline prefetch issued |
| cmd_rd | output | 1 | Command register read strobe |
| cmd_exec | output | 1 | Execute-command pulse |
| timers_halt | output | 1 | Stop both interval timers |
| refill_req | output | 1 | Refill the instruction pipeline and resume |
| isr_resume | output | 1 | Resume into the interrupt service routine |
| console_active | output | 1 | Console mode in force |

## Verification
Two functions can meet in one cycle while the console is parked: exit on interrupt and re-entry on a new pin request. The bench drives irq_pending high and req_n low on the same edge. It expects isr_resume with refill_req in the next cycle, and no command read. A second pair can also coincide: a breakpoint decode arriving while the pin is low. The sweeps over route and configuration bits, and over all sixteen command codes, check that each path takes only its own gate and gives the exit computed for its code.

// File: rtl/console_seq_pkg.sv
package console_seq_pkg;

    localparam int unsigned CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_CONTINUE = 4'h0;
    localparam logic [CMD_W-1:0] CMD_DISABLE  = 4'hB;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_PEND,
        ST_STEP,
        ST_BP_READ,
        ST_LOOP,
        ST_EXEC,
        ST_BUSY,
        ST_HALT,
        ST_SUSPEND,
        ST_EXIT_CONT,
        ST_EXIT_IRQ
    } seq_state_e;

endpackage

// File: rtl/cons_req_filter.sv
// Qualifies the request pin: true once it has been low for HOLD cycles in a row.
module cons_req_filter #(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic held
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] NEED = CW'(HOLD - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (req_n) begin
            low_cnt <= '0;
        end else if (low_cnt < NEED) begin
            low_cnt <= low_cnt + CW'(1);
        end
    end

    assign held = !req_n && (low_cnt >= NEED);
endmodule

// File: rtl/cons_loop_phase.sv
// Phase counter of the console polling loop: phase 0 samples the pin, phase 1 reads the command.
module cons_loop_phase #(
    parameter int unsigned LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output logic sample_ph,
    output logic read_ph
);
    localparam int unsigned PW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [PW-1:0] LAST  = PW'(LEN - 1);
    localparam logic [PW-1:0] RD_PH = PW'(1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (load) begin
            phase <= RD_PH;
        end else if (adv) begin
            phase <= (phase == LAST) ? '0 : phase + PW'(1);
        end
    end

    assign sample_ph = (phase == '0);
    assign read_ph   = (phase == RD_PH);
endmodule

// File: rtl/cons_step_window.sv
// Counts prefetches after a continue exit; the step window is open until FETCHES of them.
module cons_step_window #(
    parameter int unsigned FETCHES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fetch,
    output logic open
);
    localparam int unsigned CW = $clog2(FETCHES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FETCHES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (fetch && open) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign open = (cnt < LIMIT);
endmodule

// File: rtl/console_entry_seq.sv
module console_entry_seq
    import console_seq_pkg::*;
#(
    parameter int unsigned REQ_HOLD     = 2,
    parameter int unsigned LOOP_LEN     = 3,
    parameter int unsigned STEP_FETCHES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             bp_hit,
    input  logic             instr_done,
    input  logic             cfg_int_present,
    input  logic             cfg_sys_present,
    input  logic             irq_pending,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             cmd_done,
    input  logic             fetch_strobe,
    output logic             cmd_rd,
    output logic             cmd_exec,
    output logic             timers_halt,
    output logic             refill_req,
    output logic             isr_resume,
    output logic             console_active
);
    seq_state_e state, nxt;

    logic             held;
    logic             sample_ph, read_ph;
    logic             step_open;
    logic [CMD_W-1:0] cmd_q;
    logic             pin_req, bp_req, step_req;

    cons_req_filter #(.HOLD(REQ_HOLD)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .held  (held)
    );

    cons_loop_phase #(.LEN(LOOP_LEN)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((nxt == ST_LOOP) && (state != ST_LOOP)),
        .adv       (state == ST_LOOP),
        .sample_ph (sample_ph),
        .read_ph   (read_ph)
    );

    cons_step_window #(.FETCHES(STEP_FETCHES)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_EXIT_CONT),
        .fetch ((state == ST_STEP) && fetch_strobe),
        .open  (step_open)
    );

    assign pin_req  = held && cfg_int_present;
    assign bp_req   = bp_hit && cfg_sys_present;
    assign step_req = !req_n && cfg_int_present && step_open;

    // State register and command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cmd_q <= CMD_CONTINUE;
        end else begin
            state <= nxt;
            if (cmd_rd) begin
                cmd_q <= cmd_code;
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (bp_req)       nxt = ST_BP_READ;
                else if (pin_req) nxt = instr_done ? ST_LOOP : ST_PEND;
            end
            ST_PEND: begin
                if (bp_req)          nxt = ST_BP_READ;
                else if (instr_done) nxt = ST_LOOP;
            end
            ST_STEP: begin
                if (bp_req)                   nxt = ST_BP_READ;
                else if (step_req || pin_req) nxt = instr_done ? ST_LOOP : ST_PEND;
                else if (!step_open)          nxt = ST_RUN;
            end
            ST_BP_READ: nxt = ST_EXEC;
            ST_LOOP: begin
                if (sample_ph && req_n) nxt = ST_EXEC;
            end
            ST_EXEC: begin
                if (cmd_q == CMD_CONTINUE)     nxt = ST_EXIT_CONT;
                else if (cmd_q == CMD_DISABLE) nxt = ST_SUSPEND;
                else                           nxt = ST_BUSY;
            end
            ST_BUSY: begin
                if (cmd_done) nxt = ST_HALT;
            end
            ST_HALT: begin
                if (!req_n) nxt = ST_LOOP;
            end
            ST_SUSPEND: begin
                if (irq_pending) nxt = ST_EXIT_IRQ;
                else if (!req_n) nxt = ST_LOOP;
            end
            ST_EXIT_CONT: nxt = ST_STEP;
            ST_EXIT_IRQ:  nxt = ST_RUN;
            default:      nxt = ST_RUN;
        endcase
    end

    // Output decode
    always_comb begin
        cmd_rd         = 1'b0;
        cmd_exec       = 1'b0;
        timers_halt    = 1'b0;
        refill_req     = 1'b0;
        isr_resume     = 1'b0;
        console_active = 1'b0;
        unique case (state)
            ST_RUN, ST_PEND, ST_STEP: ;
            ST_BP_READ: begin
                cmd_rd         = 1'b1;
                console_active = 1'b1;
                timers_halt    = 1'b1;
            end
            ST_LOOP: begin
                cmd_rd         = read_ph;
                console_active = 1'b1;
                timers_halt    = 1'b1;
            end
            ST_EXEC: begin
                cmd_exec       = 1'b1;
                console_active = 1'b1;
                timers_halt    = 1'b1;
            end
            ST_BUSY, ST_HALT, ST_SUSPEND: begin
                console_active = 1'b1;
                timers_halt    = 1'b1;
            end
            ST_EXIT_CONT: refill_req = 1'b1;
            ST_EXIT_IRQ: begin
                refill_req = 1'b1;
                isr_resume = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/console_entry_seq_chk.sv
module console_entry_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_n,
    input logic bp_hit,
    input logic cfg_sys_present,
    input logic irq_pending,
    input logic cmd_rd,
    input logic cmd_exec,
    input logic timers_halt,
    input logic refill_req,
    input logic isr_resume,
    input logic console_active
);
    // R3: reads are single-cycle strobes and only happen in console mode
    assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> !cmd_rd);
    assert_rd_in_console_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> console_active);

    // R4: execute pulse lasts one cycle; from the loop it follows a high pin
    assert_exec_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exec |=> !cmd_exec);
    assert_exec_after_high_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exec && !$past(cmd_rd)) |-> $past(req_n));

    // R5: qualified breakpoint outside console mode reads the command next cycle
    assert_bp_reads_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit && cfg_sys_present && !console_active && !refill_req) |=> cmd_rd);

    // R7: timers follow console mode
    assert_timers_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        console_active |-> timers_halt);
    assert_timers_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !console_active |-> !timers_halt);

    // R9: refill comes as console mode drops
    assert_refill_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (!console_active && $past(console_active)));

    // R11: interrupt resume only after a pending interrupt
    assert_isr_after_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        isr_resume |-> (refill_req && $past(irq_pending)));
endmodule

bind console_entry_seq console_entry_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_n           (req_n),
    .bp_hit          (bp_hit),
    .cfg_sys_present (cfg_sys_present),
    .irq_pending     (irq_pending),
    .cmd_rd          (cmd_rd),
    .cmd_exec        (cmd_exec),
    .timers_halt     (timers_halt),
    .refill_req      (refill_req),
    .isr_resume      (isr_resume),
    .console_active  (console_active)
);

// File: tb/console_entry_seq_test.sv
module console_entry_seq_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       bp_hit = 1'b0;
    logic       instr_done = 1'b0;
    logic       cfg_int_present = 1'b0;
    logic       cfg_sys_present = 1'b0;
    logic       irq_pending = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic       cmd_done = 1'b0;
    logic       fetch_strobe = 1'b0;
    logic       cmd_rd, cmd_exec, timers_halt, refill_req, isr_resume, console_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    console_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .bp_hit(bp_hit),
        .instr_done(instr_done), .cfg_int_present(cfg_int_present),
        .cfg_sys_present(cfg_sys_present), .irq_pending(irq_pending),
        .cmd_code(cmd_code), .cmd_done(cmd_done), .fetch_strobe(fetch_strobe),
        .cmd_rd(cmd_rd), .cmd_exec(cmd_exec), .timers_halt(timers_halt),
        .refill_req(refill_req), .isr_resume(isr_resume),
        .console_active(console_active)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_n = 1'b1; bp_hit = 1'b0; instr_done = 1'b0;
        cfg_int_present = 1'b0; cfg_sys_present = 1'b0; irq_pending = 1'b0;
        cmd_code = 4'h0; cmd_done = 1'b0; fetch_strobe = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Breakpoint entry; returns at the cycle where cmd_exec is high
    task automatic bp_to_exec(input logic [3:0] code);
        cmd_code = code; cfg_sys_present = 1'b1; bp_hit = 1'b1;
        tick();
        bp_hit = 1'b0;
        tick();
    endtask

    // Wait up to 6 cycles for cmd_exec; returns at that cycle
    task automatic wait_exec(output int found);
        found = 0;
        for (int i = 0; i < 6 && found == 0; i++) begin
            tick();
            if (cmd_exec) found = 1;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int found, rd_cnt, ex_cnt, th_cnt, act_cnt;

        // R1 reset state
        do_reset();
        check("R1 cmd_rd", cmd_rd, 0);
        check("R1 cmd_exec", cmd_exec, 0);
        check("R1 timers_halt", timers_halt, 0);
        check("R1 refill_req", refill_req, 0);
        check("R1 isr_resume", isr_resume, 0);
        check("R1 console_active", console_active, 0);

        // R2 one-cycle pulse is not a request
        cfg_int_present = 1'b1;
        req_n = 1'b0; tick(); req_n = 1'b1; tick();
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        act_cnt = 0;
        for (int i = 0; i < 3; i++) begin tick(); act_cnt += console_active; end
        check("R2 short pulse ignored", act_cnt, 0);

        // R2 held request waits for instruction completion
        req_n = 1'b0; tick(); tick();
        act_cnt = 0;
        for (int i = 0; i < 3; i++) begin act_cnt += console_active; tick(); end
        check("R2 no entry before instr_done", act_cnt, 0);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        check("R2 entry active", console_active, 1);
        check("R2 first read", cmd_rd, 1);

        // R3 / R7 loop while pin low
        rd_cnt = 0; ex_cnt = 0; th_cnt = 0;
        for (int i = 0; i < 9; i++) begin
            tick(); rd_cnt += cmd_rd; ex_cnt += cmd_exec; th_cnt += timers_halt;
        end
        check("R3 reads per 9 cycles", rd_cnt, 3);
        check("R3 no exec while low", ex_cnt, 0);
        check("R7 timers halted in loop", th_cnt, 9);
        check("R3 read phase", cmd_rd, 1);

        // R4 latched command runs, later change ignored
        cmd_code = 4'h5; tick();
        cmd_code = 4'h0; req_n = 1'b1; tick();
        check("R4 no exec in sample", cmd_exec, 0);
        tick();
        check("R4 exec pulse", cmd_exec, 1);
        tick();
        check("R4 exec single", cmd_exec, 0);
        check("R4 latched code not continue", refill_req, 0);

        // R8 waits for done, then halts
        act_cnt = 0;
        for (int i = 0; i < 3; i++) begin tick(); act_cnt += console_active; end
        check("R8 busy stays in console", act_cnt, 3);
        cmd_done = 1'b1; tick(); cmd_done = 1'b0;
        rd_cnt = 0; ex_cnt = 0;
        for (int i = 0; i < 4; i++) begin tick(); rd_cnt += cmd_rd; ex_cnt += cmd_exec; end
        check("R8 halt no read", rd_cnt, 0);
        check("R8 halt no exec", ex_cnt, 0);
        req_n = 1'b0; tick();
        check("R8 read after fall", cmd_rd, 1);

        // R9 continue exit
        cmd_code = 4'h0; tick(); tick(); req_n = 1'b1;
        wait_exec(found);
        check("R4 exec after rise", found, 1);
        tick();
        check("R9 refill", refill_req, 1);
        check("R9 active low at refill", console_active, 0);
        check("R9 timers run at refill", timers_halt, 0);
        tick();
        check("R9 refill single", refill_req, 0);

        // R10 single step inside window
        req_n = 1'b0; tick(); req_n = 1'b1; tick();
        check("R10 one instruction runs first", console_active, 0);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        check("R10 re-entry active", console_active, 1);
        check("R10 re-entry read", cmd_rd, 1);

        // R10 window closed after two prefetches
        wait_exec(found); tick();
        check("R9 second exit", refill_req, 1);
        tick();
        fetch_strobe = 1'b1; tick(); tick(); fetch_strobe = 1'b0; tick();
        req_n = 1'b0; tick(); req_n = 1'b1;
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        act_cnt = 0;
        for (int i = 0; i < 3; i++) begin tick(); act_cnt += console_active; end
        check("R10 closed window needs hold", act_cnt, 0);

        // R5 breakpoint entry with pin high
        do_reset();
        cfg_sys_present = 1'b1; cmd_code = 4'h0; bp_hit = 1'b1; tick(); bp_hit = 1'b0;
        check("R5 bp read", cmd_rd, 1);
        check("R5 bp active", console_active, 1);
        tick();
        check("R5 bp exec", cmd_exec, 1);
        tick();
        check("R9 bp continue refill", refill_req, 1);

        // R6 sweep: route x configuration bits
        for (int ci = 0; ci < 2; ci++) begin
            for (int cs = 0; cs < 2; cs++) begin
                for (int route = 0; route < 2; route++) begin
                    do_reset();
                    cfg_int_present = ci[0]; cfg_sys_present = cs[0];
                    cmd_code = 4'h5;
                    if (route == 0) begin
                        req_n = 1'b0; tick(); tick(); tick();
                        instr_done = 1'b1; tick(); instr_done = 1'b0;
                    end else begin
                        bp_hit = 1'b1; tick(); bp_hit = 1'b0;
                    end
                    act_cnt = 0;
                    for (int i = 0; i < 2; i++) begin act_cnt += console_active; tick(); end
                    check($sformatf("R6 route%0d int%0d sys%0d", route, ci, cs),
                          (act_cnt > 0) ? 1 : 0, (route == 0) ? ci : cs);
                end
            end
        end

        // Command code sweep: R8, R9, R11
        for (int c = 0; c < 16; c++) begin
            do_reset();
            bp_to_exec(4'(c));
            check($sformatf("R5 exec code %0d", c), cmd_exec, 1);
            tick();
            if (c == 0) begin
                check("R9 sweep refill", refill_req, 1);
            end else if (c == 11) begin
                rd_cnt = 0; act_cnt = 0;
                for (int i = 0; i < 3; i++) begin
                    rd_cnt += cmd_rd; act_cnt += console_active; tick();
                end
                check("R11 suspended no read", rd_cnt, 0);
                check("R11 suspended active", act_cnt, 3);
                irq_pending = 1'b1; tick(); irq_pending = 1'b0;
                check("R11 irq refill", refill_req, 1);
                check("R11 irq isr_resume", isr_resume, 1);
            end else begin
                check($sformatf("R8 code %0d no refill", c), refill_req, 0);
                cmd_done = 1'b1; tick(); cmd_done = 1'b0;
                ex_cnt = 0; act_cnt = 0;
                for (int i = 0; i < 3; i++) begin
                    tick(); ex_cnt += cmd_exec; act_cnt += console_active;
                end
                check($sformatf("R8 code %0d halted", c), act_cnt - 3 * ex_cnt, 3);
            end
        end

        // R11 pin resume from suspend
        do_reset();
        bp_to_exec(4'hB); tick(); tick();
        req_n = 1'b0; tick();
        check("R11 pin read", cmd_rd, 1);

        // R11 interrupt and pin in the same cycle
        do_reset();
        bp_to_exec(4'hB); tick(); tick();
        req_n = 1'b0; irq_pending = 1'b1; tick(); irq_pending = 1'b0;
        check("R11 irq priority", isr_resume, 1);
        check("R11 irq priority no read", cmd_rd, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule